// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Decoder

This block is the digital front end of a two-channel digital-to-analog converter. It listens on a three-wire serial port made up of a bit clock, an active-low frame enable and a data line. While the frame enable is low, it collects one 16-bit command word, most significant bit first, on falling edges of the bit clock. On the sixteenth edge it carries out the command. A command can load a channel's holding register, move the holding registers to the active output codes, or power both outputs down with a chosen output termination.

The serial pins are oversampled by a local clock through a synchronizer of parameterized depth. Every register of the decoder lives in that one clock domain. The analog stage reads the two active 8-bit codes, the power-down flag and the 2-bit termination code.

Top module: `dacser_core`

## Requirements
- R1: After reset, both active codes are 0, the power-down flag is 0 and the termination code is 00, and they stay that way until a valid command executes.
- R2: While frame enable is low, a bit is taken from the data line on each falling edge of the bit clock, most significant bit first. The command executes on the sixteenth falling edge, so its result is visible at the outputs while frame enable is still low.
- R3: Word layout: bit 15 is the leading bit and bit 14 is the channel address (0 = A, 1 = B). Bits 13:12 are the mode. Mode 00 loads the addressed holding register only, and both active codes keep their values.
- R4: Mode 01 loads the addressed holding register. Both active codes then take the two holding registers, including the new value.
- R5: Mode 10 loads both holding registers with the data, and both active codes take that value.
- R6: The 8-bit channel code is bits 11:4 of the word. Bits 3:0 have no effect.
- R7: Mode 11 sets the power-down flag and leaves both holding registers and both active codes unchanged. Bits 15:14 choose the termination code: 01 gives 01 (low-ohm pull-down), 10 gives 10 (high-ohm pull-down), and 00 or 11 give 00 (high impedance). The leading bit is accepted in this mode.
- R8: Any accepted command in modes 00, 01 or 10 clears the power-down flag and sets the termination code to 00. Its own register write happens in that same frame. Holding registers keep their values through power-down.
- R9: If frame enable rises before the sixteenth falling edge, the frame is dropped and no output or register changes.
- R10: Falling edges after the sixteenth, within the same low period of frame enable, change nothing.
- R11: A word with leading bit 1 in modes 00, 01 or 10 is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| sclk | input | 1 | Serial bit clock, sampled on its falling edge |
| sync_n | input | 1 | Active-low frame enable |
| din | input | 1 | Serial data |
| code_a | output | 8 | Active code for channel A |
| code_b | output | 8 | Active code for channel B |
| pwr_down | output | 1 | Both outputs powered down |
| term_sel | output | 2 | Output termination: 00 high impedance, 01 low-ohm, 10 high-ohm |

## Verification
Some properties are checked on every cycle:
- the bit counter clears whenever the frame closes;
- a word is released only once the counter is full, and as a single pulse;
- the shift register freezes after sixteen edges;
- a mode-00 or power-down command never moves the active codes;
- a write command with a leading one leaves all state untouched;
- the termination code is 00 whenever the block is awake.

Other behaviours are shown only by the bench's frame scenarios: the value mapping of each mode, the bit order, data truncation, the termination decode, holding values surviving power-down and wake-up, and aborted frames.

// File: rtl/dacser_pkg.sv
package dacser_pkg;

    typedef enum logic [1:0] {
        MODE_LOAD_HOLD = 2'b00,
        MODE_LOAD_SHOW = 2'b01,
        MODE_LOAD_BOTH = 2'b10,
        MODE_SLEEP     = 2'b11
    } mode_e;

    localparam logic [1:0] TERM_OPEN   = 2'b00;
    localparam logic [1:0] TERM_LOW_R  = 2'b01;
    localparam logic [1:0] TERM_HIGH_R = 2'b10;

    localparam int HDR_BITS = 4;

endpackage

// File: rtl/dacser_insync.sv
module dacser_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sync_n,
    input  logic din,
    output logic sclk_fall,
    output logic frame_open,
    output logic bit_s
);
    typedef struct packed {
        logic [STAGES-1:0] sclk_sh;
        logic [STAGES-1:0] sync_sh;
        logic [STAGES-1:0] din_sh;
        logic              sclk_prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_sh   = {st_q.sclk_sh[STAGES-2:0], sclk};
        st_d.sync_sh   = {st_q.sync_sh[STAGES-2:0], sync_n};
        st_d.din_sh    = {st_q.din_sh[STAGES-2:0], din};
        st_d.sclk_prev = st_q.sclk_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_sh   <= '0;
            st_q.sync_sh   <= '1;
            st_q.din_sh    <= '0;
            st_q.sclk_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_fall  = st_q.sclk_prev & ~st_q.sclk_sh[STAGES-1];
    assign frame_open = ~st_q.sync_sh[STAGES-1];
    assign bit_s      = st_q.din_sh[STAGES-1];

    // R2: each synchronized falling edge is a single-cycle event
    a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |=> !sclk_fall);

endmodule

// File: rtl/dacser_shifter.sv
module dacser_shifter #(
    parameter int FRAME_BITS = 16,
    parameter int KEEP_BITS  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_fall,
    input  logic                 frame_open,
    input  logic                 bit_s,
    output logic                 word_vld,
    output logic [KEEP_BITS-1:0] word
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic [CNT_W-1:0]      cnt;
        logic                  vld;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!frame_open) begin
            st_d.cnt = '0;
        end else if (sclk_fall && (st_q.cnt != CNT_FULL)) begin
            st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], bit_s};
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.vld   = (st_q.cnt == CNT_LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld = st_q.vld;
    assign word     = st_q.shreg[FRAME_BITS-1 -: KEEP_BITS];

    // R9: a closed frame always restarts the bit count
    a_r9_closed_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_open |=> (st_q.cnt == '0));

    // R2: a word is only released once all frame bits have arrived
    a_r2_vld_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (st_q.cnt == CNT_FULL));

    // R10: one word per frame and no shifting once full
    a_r10_single_word: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    a_r10_frozen_full: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_open && st_q.cnt == CNT_FULL) |=> $stable(st_q.shreg));

endmodule

// File: rtl/dacser_exec.sv
module dacser_exec
    import dacser_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int KEEP_W = CODE_W + HDR_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [KEEP_W-1:0] word,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              sleep,
    output logic [1:0]        term
);
    localparam int NCH = 2;

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] hold;
        logic [NCH-1:0][CODE_W-1:0] outc;
        logic                       sleep;
        logic [1:0]                 term;
    } st_t;

    st_t st_d, st_q;

    logic              lead;
    logic              addr;
    mode_e             mode;
    logic [CODE_W-1:0] data;

    assign lead = word[KEEP_W-1];
    assign addr = word[KEEP_W-2];
    assign mode = mode_e'(word[KEEP_W-3 -: 2]);
    assign data = word[CODE_W-1:0];

    always_comb begin
        st_d = st_q;
        if (word_vld) begin
            if (mode == MODE_SLEEP) begin
                st_d.sleep = 1'b1;
                case ({lead, addr})
                    2'b01:   st_d.term = TERM_LOW_R;
                    2'b10:   st_d.term = TERM_HIGH_R;
                    default: st_d.term = TERM_OPEN;
                endcase
            end else if (!lead) begin
                st_d.sleep = 1'b0;
                st_d.term  = TERM_OPEN;
                for (int ch = 0; ch < NCH; ch++) begin
                    if ((mode == MODE_LOAD_BOTH) || (int'(addr) == ch)) begin
                        st_d.hold[ch] = data;
                    end
                end
                if (mode != MODE_LOAD_HOLD) begin
                    st_d.outc = st_d.hold;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_a = st_q.outc[0];
    assign code_b = st_q.outc[1];
    assign sleep  = st_q.sleep;
    assign term   = st_q.term;

    // R3: a hold-only load never moves the active codes
    a_r3_hold_only: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !lead && mode == MODE_LOAD_HOLD) |=> $stable(st_q.outc));

    // R7: power-down keeps both register sets and raises the flag
    a_r7_sleep_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && mode == MODE_SLEEP) |=> ($stable(st_q.hold) && $stable(st_q.outc) && st_q.sleep));

    // R11: a write word with a leading one leaves all state as it was
    a_r11_lead_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && lead && mode != MODE_SLEEP) |=> $stable(st_q));

    // R8: the termination code is open whenever the outputs are awake
    a_r8_awake_open: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.sleep |-> (st_q.term == TERM_OPEN));

endmodule

// File: rtl/dacser_core.sv
module dacser_core
    import dacser_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_BITS  = 16,
    parameter int CODE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              din,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              pwr_down,
    output logic [1:0]        term_sel
);
    localparam int KEEP_W = CODE_W + HDR_BITS;

    logic              sclk_fall;
    logic              frame_open;
    logic              bit_s;
    logic              word_vld;
    logic [KEEP_W-1:0] word;

    dacser_insync #(.STAGES(SYNC_STAGES)) u_insync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .sync_n     (sync_n),
        .din        (din),
        .sclk_fall  (sclk_fall),
        .frame_open (frame_open),
        .bit_s      (bit_s)
    );

    dacser_shifter #(.FRAME_BITS(FRAME_BITS), .KEEP_BITS(KEEP_W)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_fall  (sclk_fall),
        .frame_open (frame_open),
        .bit_s      (bit_s),
        .word_vld   (word_vld),
        .word       (word)
    );

    dacser_exec #(.CODE_W(CODE_W), .KEEP_W(KEEP_W)) u_exec (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .word     (word),
        .code_a   (code_a),
        .code_b   (code_b),
        .sleep    (pwr_down),
        .term     (term_sel)
    );

endmodule

// File: tb/dacser_core_tb_top.sv
module dacser_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sync_n = 1'b1;
    logic       din = 1'b0;
    logic [7:0] code_a, code_b;
    logic       pwr_down;
    logic [1:0] term_sel;

    always #10 clk = ~clk;

    dacser_core dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
        .code_a(code_a), .code_b(code_b), .pwr_down(pwr_down), .term_sel(term_sel)
    );

    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        logic       pd;
        logic [1:0] t;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   ended = 1'b0;

    // reference state kept from the requirements
    logic [7:0] m_hold[2];
    logic [7:0] m_out[2];
    logic       m_pd;
    logic [1:0] m_t;

    task automatic model(input logic [15:0] w);
        logic [1:0] m = w[13:12];
        logic [7:0] c = w[11:4];
        if (m == 2'b11) begin
            m_pd = 1'b1;
            m_t  = (w[15:14] == 2'b01) ? 2'b01 : (w[15:14] == 2'b10) ? 2'b10 : 2'b00;
        end else if (!w[15]) begin
            m_pd = 1'b0;
            m_t  = 2'b00;
            if (m == 2'b10) begin
                m_hold[0] = c;
                m_hold[1] = c;
            end else begin
                m_hold[w[14]] = c;
            end
            if (m != 2'b00) begin
                m_out[0] = m_hold[0];
                m_out[1] = m_hold[1];
            end
        end
    endtask

    task automatic push(input string req);
        exp_t e;
        e.a = m_out[0]; e.b = m_out[1]; e.pd = m_pd; e.t = m_t; e.req = req;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic clk_bit(input logic v);
        din = v;
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // nbits < 16 aborts the frame; extra edges follow a full frame
    task automatic send(input logic [15:0] w, input int nbits, input int extra, input string req);
        sync_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbits; i++) clk_bit(w[15-i]);
        if (nbits >= 16) begin
            for (int i = 0; i < extra; i++) clk_bit(i[0]);
            model(w);
            push(req);
            sync_n = 1'b1;
            din = 1'b0;
            repeat (4) @(negedge clk);
        end else begin
            sync_n = 1'b1;
            din = 1'b0;
            repeat (4) @(negedge clk);
            push(req);
        end
    endtask

    // monitor: compare the oldest expectation once the outputs have settled
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            repeat (6) @(negedge clk);
            n_vec++;
            if (code_a !== exp_q[0].a || code_b !== exp_q[0].b ||
                pwr_down !== exp_q[0].pd || term_sel !== exp_q[0].t) begin
                n_bad++;
                $display("FAIL %s: got a=%h b=%h pd=%b t=%b, expected a=%h b=%h pd=%b t=%b",
                         exp_q[0].req, code_a, code_b, pwr_down, term_sel,
                         exp_q[0].a, exp_q[0].b, exp_q[0].pd, exp_q[0].t);
            end
            void'(exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        m_hold[0] = 8'h00; m_hold[1] = 8'h00;
        m_out[0] = 8'h00; m_out[1] = 8'h00;
        m_pd = 1'b0; m_t = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        push("R1 reset state");
        send(16'h05A3, 16, 0, "R3 R6 hold-only load A, low bits dropped");
        send(16'h53C0, 16, 0, "R4 load B and show both");
        send(16'h2FFF, 16, 0, "R5 load both");
        send(16'h0110, 16, 0, "R3 hold A=11");
        send(16'h5220, 16, 0, "R4 show A=11 B=22");
        send(16'h2000, 10, 0, "R9 aborted frame");
        send(16'h2000, 15, 0, "R9 abort at fifteen edges");
        send(16'h280F, 16, 8, "R2 R10 executes on 16th edge, extra edges ignored");
        send(16'hA000, 16, 0, "R11 leading one ignored");
        send(16'h7000, 16, 0, "R7 power-down low-ohm");
        send(16'hB000, 16, 0, "R7 power-down high-ohm, leading one accepted");
        send(16'hF000, 16, 0, "R7 power-down code 11 open");
        send(16'h3000, 16, 0, "R7 power-down code 00 open");
        send(16'h0440, 16, 0, "R8 hold-only load wakes outputs");
        send(16'h7000, 16, 0, "R7 power-down again");
        send(16'h5660, 16, 0, "R8 wake with show keeps held A");
        ended = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule